// File: doc/BRIEF.md
# Strobed Nibble-Bus Receiver Model

This block stands in for the receiving side of a character display's parallel write port. On every enable strobe it takes one nibble from a four-line data bus together with the register-select line. It turns these nibbles into whole bytes according to its current interface width. In wide mode every strobe gives a byte. In narrow mode two strobes give one byte, the first nibble going to the high half and the second to the low half.

The receiver keeps its nibble phase and interface width across a reset of the host that drives it. Only its own power-on reset clears them. So when a host restarts halfway through a byte, the receiver stays out of step with it. This lets a host-side initialisation sequencer be tested for recovery from any phase the receiver may be in. A command byte whose upper nibble is the wide code switches the receiver to wide mode, and one whose upper nibble is the narrow code switches it to narrow mode. Each switch applies from the next strobe onward.

Top module: `nasm_top`

## Requirements
- R1: While `por_i` is high, and in the first cycle after it falls, `valid_o` is 0 and `mode4_o` is 0 (wide mode). The nibble phase returns to the high half, so the next narrow-mode byte starts fresh.
- R2: In wide mode, a strobe in cycle k makes `valid_o` 1 in cycle k+1. In that cycle `byte_o` is the bus nibble in bits 7:4 with zeros in bits 3:0, and `rs_o` is the `rs_i` value from cycle k.
- R3: In narrow mode, the first strobe of a byte gives no `valid_o`. The second strobe makes `valid_o` 1 one cycle later, with `byte_o` = {first nibble, second nibble} and `rs_o` taken from the first strobe.
- R4: A completed byte with `rs_o` = 0 and bits 7:4 = 0x3 leaves `mode4_o` at 0. `mode4_o` changes in the same cycle that `valid_o` rises for that byte.
- R5: A completed byte with `rs_o` = 0 and bits 7:4 = 0x2 leaves `mode4_o` at 1, with the same timing as in R4.
- R6: A width change applies to the strobe that follows the completing strobe, even when the two strobes are in back-to-back cycles. The phase then starts at the high half.
- R7: `host_rst_i` has no effect. A byte left half assembled across it is completed by the next strobe, which supplies the low half.
- R8: From wide mode or from either narrow phase, the strobe sequence 0x3, 0x3, 0x3, 0x2 with `rs_i` = 0 leaves the receiver in narrow mode at the high phase.
- R9: `valid_o` is 1 only in the cycle after a completing strobe. A byte with `rs_o` = 1, or with an upper nibble other than the two codes, leaves the width unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Synchronous active-high power-on reset |
| host_rst_i | input | 1 | Host-side reset; ignored by the receiver |
| strb_i | input | 1 | Enable strobe, one sample per high cycle |
| nib_i | input | 4 | Data nibble on the bus |
| rs_i | input | 1 | Register-select line (0 = command) |
| byte_o | output | 8 | Last decoded byte |
| valid_o | output | 1 | One-cycle pulse when `byte_o` is new |
| rs_o | output | 1 | Register-select value belonging to `byte_o` |
| mode4_o | output | 1 | 1 = narrow (two-strobe) mode, 0 = wide mode |

## Verification
Completing a byte and switching the width both happen on the same clock edge. Any misordering between the two shows up only when the next strobe follows at once. The bench provokes this by sending a width-switching command and then a further nibble in the very next cycle, in both directions. It judges the result by requiring the new width flag in the same cycle as the valid pulse, and by requiring the immediately following nibble to decode under the new width. Sweeps over every byte value in both widths, and resync runs from every possible stale high nibble, are checked against a bench-side arithmetic model.

// File: rtl/nasm_pkg.sv
package nasm_pkg;
  typedef enum logic {
    IF_WIDE   = 1'b0,
    IF_NARROW = 1'b1
  } if_mode_e;

  typedef enum logic {
    PH_HI = 1'b0,
    PH_LO = 1'b1
  } nib_phase_e;
endpackage

// File: rtl/nasm_phase.sv
// Nibble phase tracker and byte assembler; completion outputs are combinational.
module nasm_phase
  import nasm_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              strb_i,
  input  if_mode_e          mode_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              rs_i,
  output logic              fire_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              rs_o
);
  nib_phase_e       phase_q;
  logic [NIB_W-1:0] hi_q;
  logic             rs_q;

  always_comb begin
    fire_o = strb_i && ((mode_i == IF_WIDE) || (phase_q == PH_LO));
    if (mode_i == IF_WIDE) begin
      byte_o = {nib_i, {NIB_W{1'b0}}};
      rs_o   = rs_i;
    end else begin
      byte_o = {hi_q, nib_i};
      rs_o   = rs_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      phase_q <= PH_HI;
      hi_q    <= '0;
      rs_q    <= 1'b0;
    end else if (strb_i) begin
      if (mode_i == IF_WIDE) begin
        phase_q <= PH_HI;
      end else if (phase_q == PH_HI) begin
        hi_q    <= nib_i;
        rs_q    <= rs_i;
        phase_q <= PH_LO;
      end else begin
        phase_q <= PH_HI;
      end
    end
  end
endmodule

// File: rtl/nasm_mode.sv
// Interface width register, updated by completed command bytes.
module nasm_mode
  import nasm_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter logic [NIB_W-1:0] WIDE_CODE = 4'h3,
  parameter logic [NIB_W-1:0] NARROW_CODE = 4'h2,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              fire_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rs_i,
  output if_mode_e          mode_o
);
  logic [NIB_W-1:0] upper;
  assign upper = byte_i[BYTE_W-1:NIB_W];

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      mode_o <= IF_WIDE;
    end else if (fire_i && !rs_i) begin
      if (upper == WIDE_CODE) begin
        mode_o <= IF_WIDE;
      end else if (upper == NARROW_CODE) begin
        mode_o <= IF_NARROW;
      end
    end
  end
endmodule

// File: rtl/nasm_outreg.sv
// Registered output stage for decoded bytes.
module nasm_outreg #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              fire_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rs_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              rs_o
);
  always_ff @(posedge clk_i) begin
    if (por_i) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
      rs_o    <= 1'b0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        byte_o <= byte_i;
        rs_o   <= rs_i;
      end
    end
  end
endmodule

// File: rtl/nasm_top.sv
module nasm_top
  import nasm_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter logic [NIB_W-1:0] WIDE_CODE = 4'h3,
  parameter logic [NIB_W-1:0] NARROW_CODE = 4'h2,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              host_rst_i,
  input  logic              strb_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              rs_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o,
  output logic              rs_o,
  output logic              mode4_o
);
  if_mode_e          mode_q;
  logic              fire;
  logic [BYTE_W-1:0] cmp_byte;
  logic              cmp_rs;
  logic              unused_host_rst;

  // The host reset belongs to the other side of the bus; the receiver keeps its state.
  assign unused_host_rst = host_rst_i;

  nasm_phase #(.NIB_W(NIB_W)) phase_i (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .strb_i (strb_i),
    .mode_i (mode_q),
    .nib_i  (nib_i),
    .rs_i   (rs_i),
    .fire_o (fire),
    .byte_o (cmp_byte),
    .rs_o   (cmp_rs)
  );

  nasm_mode #(
    .NIB_W      (NIB_W),
    .WIDE_CODE  (WIDE_CODE),
    .NARROW_CODE(NARROW_CODE)
  ) mode_i (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .fire_i (fire),
    .byte_i (cmp_byte),
    .rs_i   (cmp_rs),
    .mode_o (mode_q)
  );

  nasm_outreg #(.NIB_W(NIB_W)) out_i (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .fire_i (fire),
    .byte_i (cmp_byte),
    .rs_i   (cmp_rs),
    .valid_o(valid_o),
    .byte_o (byte_o),
    .rs_o   (rs_o)
  );

  assign mode4_o = (mode_q == IF_NARROW);
endmodule

// File: rtl/nasm_checker.sv
module nasm_checker #(
  parameter int NIB_W = 4,
  parameter logic [NIB_W-1:0] WIDE_CODE = 4'h3,
  parameter logic [NIB_W-1:0] NARROW_CODE = 4'h2,
  localparam int BYTE_W = 2 * NIB_W
) (
  input logic              clk_i,
  input logic              por_i,
  input logic              strb_i,
  input logic [NIB_W-1:0]  nib_i,
  input logic              rs_i,
  input logic [BYTE_W-1:0] byte_o,
  input logic              valid_o,
  input logic              rs_o,
  input logic              mode4_o
);
  AST_POR_STATE: assert property (@(posedge clk_i) por_i |=> (!valid_o && !mode4_o)); // R1

  AST_WIDE_BYTE: assert property (@(posedge clk_i) disable iff (por_i)
    (strb_i && !mode4_o) |=> (valid_o && byte_o == {$past(nib_i), {NIB_W{1'b0}}} && rs_o == $past(rs_i))); // R2

  AST_WIDE_SELECT: assert property (@(posedge clk_i) disable iff (por_i)
    (valid_o && !rs_o && byte_o[BYTE_W-1:NIB_W] == WIDE_CODE) |-> !mode4_o); // R4

  AST_NARROW_SELECT: assert property (@(posedge clk_i) disable iff (por_i)
    (valid_o && !rs_o && byte_o[BYTE_W-1:NIB_W] == NARROW_CODE) |-> mode4_o); // R5

  AST_MODE_WITH_BYTE: assert property (@(posedge clk_i) disable iff (por_i)
    (!$past(por_i) && !$stable(mode4_o)) |-> valid_o); // R4

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (por_i)
    !strb_i |=> !valid_o); // R9
endmodule

bind nasm_top nasm_checker #(
  .NIB_W      (NIB_W),
  .WIDE_CODE  (WIDE_CODE),
  .NARROW_CODE(NARROW_CODE)
) chk_i (
  .clk_i  (clk_i),
  .por_i  (por_i),
  .strb_i (strb_i),
  .nib_i  (nib_i),
  .rs_i   (rs_i),
  .byte_o (byte_o),
  .valid_o(valid_o),
  .rs_o   (rs_o),
  .mode4_o(mode4_o)
);

// File: tb/nasm_top_tb_top.sv
module nasm_top_tb_top;
  logic       clk_i = 1'b0;
  logic       por_i = 1'b1;
  logic       host_rst_i = 1'b0;
  logic       strb_i = 1'b0;
  logic [3:0] nib_i = 4'h0;
  logic       rs_i = 1'b0;
  logic [7:0] byte_o;
  logic       valid_o;
  logic       rs_o;
  logic       mode4_o;

  always #4 clk_i = ~clk_i;

  nasm_top dut_i (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .host_rst_i(host_rst_i),
    .strb_i    (strb_i),
    .nib_i     (nib_i),
    .rs_i      (rs_i),
    .byte_o    (byte_o),
    .valid_o   (valid_o),
    .rs_o      (rs_o),
    .mode4_o   (mode4_o)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  bit    armed = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // bench-side reference model
  bit       m_narrow = 0;
  bit       m_lo = 0;
  bit [3:0] m_hi = 0;
  bit       m_rs = 0;
  bit       e_valid = 0;
  bit [7:0] e_byte = 0;
  bit       e_rs = 0;

  task automatic expect_bit(input string tag, input string what, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %0b exp %0b", tag, what, got, exp);
    end
  endtask

  task automatic check_prev();
    if (armed) begin
      expect_bit(cur_tag, "valid_o", valid_o, e_valid);
      expect_bit(cur_tag, "mode4_o", mode4_o, m_narrow);
      if (e_valid) begin
        n_checks++;
        if (byte_o !== e_byte || rs_o !== e_rs) begin
          n_fail++;
          $display("FAIL %s byte/rs got %h/%0b exp %h/%0b", cur_tag, byte_o, rs_o, e_byte, e_rs);
        end
      end
    end
  endtask

  task automatic model_complete(input bit [7:0] b, input bit r);
    e_valid = 1;
    e_byte  = b;
    e_rs    = r;
    if (!r && b[7:4] == 4'h3) m_narrow = 0;
    else if (!r && b[7:4] == 4'h2) m_narrow = 1;
    m_lo = 0;
  endtask

  task automatic step(input bit s, input bit [3:0] n, input bit r, input bit hr, input string tag);
    @(negedge clk_i);
    check_prev();
    strb_i = s; nib_i = n; rs_i = r; host_rst_i = hr;
    e_valid = 0;
    if (s) begin
      if (!m_narrow) model_complete({n, 4'h0}, r);
      else if (!m_lo) begin m_hi = n; m_rs = r; m_lo = 1; end
      else model_complete({m_hi, n}, m_rs);
    end
    cur_tag = tag;
  endtask

  task automatic do_por();
    @(negedge clk_i);
    check_prev();
    strb_i = 0; por_i = 1;
    @(negedge clk_i);
    por_i = 0;
    m_narrow = 0; m_lo = 0; e_valid = 0;
    cur_tag = "R1";
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    por_i = 0;
    armed = 1;
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");

    // R2 / R9: wide sweep, every nibble and select value except the narrow command
    for (int n = 0; n < 16; n++)
      for (int r = 0; r < 2; r++)
        if (!(n == 2 && r == 0)) begin
          step(1, 4'(n), 1'(r), 0, (n == 3 || n == 2) ? "R9" : "R2");
          step(0, 0, 0, 0, "R9");
        end
    step(1, 4'h2, 0, 0, "R5");
    step(0, 0, 0, 0, "R5");

    // R3: narrow sweep over all bytes, staying narrow
    for (int b = 0; b < 256; b++)
      for (int r = 0; r < 2; r++)
        if (!(b[7:4] == 4'h3 && r == 0)) begin
          step(1, 4'(b >> 4), 1'(r), 0, "R3");
          if (b[0]) step(0, 0, 0, 0, "R3");
          step(1, 4'(b), ~1'(r), 0, (b[7:4] == 4'h3) ? "R9" : "R3");
        end
    step(0, 0, 0, 0, "R3");

    // R4 / R6: switch to wide, next strobe back-to-back
    step(1, 4'h3, 0, 0, "R4");
    step(1, 4'h5, 1, 0, "R4");
    step(1, 4'h7, 1, 0, "R6");
    // R5 / R6: switch to narrow, then a back-to-back byte
    step(1, 4'h2, 0, 0, "R5");
    step(1, 4'h9, 1, 0, "R6");
    step(1, 4'h4, 0, 0, "R6");
    step(0, 0, 0, 0, "R6");

    // R7: host reset in the middle of a byte
    step(1, 4'hC, 1, 0, "R7");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, "R7");
    step(1, 4'h6, 0, 1, "R7");
    step(0, 0, 0, 0, "R7");

    // R8: resync from wide, narrow-high and narrow-low with every stale high nibble
    for (int start = 0; start < 18; start++) begin
      do_por();
      if (start >= 1) step(1, 4'h2, 0, 0, "R8");
      if (start >= 2) step(1, 4'(start - 2), 1, 0, "R8");
      step(1, 4'h3, 0, 1, "R8");
      step(1, 4'h3, 0, 1, "R8");
      step(1, 4'h3, 0, 1, "R8");
      step(1, 4'h2, 0, 0, "R8");
      step(0, 0, 0, 0, "R8");
      n_checks++;
      if (!(m_narrow && !m_lo)) begin
        n_fail++;
        $display("FAIL R8 model state got %0b/%0b exp 1/0", m_narrow, m_lo);
      end
      step(1, 4'hA, 1, 0, "R8");
      step(1, 4'h5, 1, 0, "R8");
      step(0, 0, 0, 0, "R8");
    end

    // R1: power-on reset from narrow mode mid-byte
    step(1, 4'h2, 0, 0, "R1");
    step(1, 4'hE, 0, 0, "R1");
    do_por();
    step(0, 0, 0, 0, "R1");
    step(1, 4'hB, 1, 0, "R1");
    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      finish_run();
    end
  end
endmodule